// File: doc/BRIEF.md
# UART Receive Queue with Automatic Flow Control

This block is the receive-side buffer of one UART channel. The receive shift register hands it finished characters, each with three error flags. The block keeps them in order in a 64-entry queue, and the host drains that queue one entry per read strobe. Each entry is 11 bits wide, so a character and its own parity, framing and break flags always leave the queue together.

From the fill count the block derives three things:

- a data-ready status bit;
- a threshold status bit and the receive interrupt, both based on a programmable trigger level;
- an active-low request-to-send output.

The request-to-send output has a symmetric hysteresis band around the trigger level, so the remote transmitter pauses and resumes without software help. When automatic flow control is off, that output follows a manual control bit. When queueing is disabled, the block acts as a one-entry holding register. All control fields arrive as plain input ports.

Top module: `uart_rx_queue`

## Requirements
- R1: Characters leave in arrival order, up to 64 stored. A read strobe on a non-empty queue puts the oldest entry on `rd_data_o`/`rd_err_o` after the next clock edge. In `rd_err_o`, bit 2 is the break flag, bit 1 the framing flag and bit 0 the parity flag.
- R2: `data_rdy_o` is high in the cycle after the first character is stored. It falls only when a read leaves the queue empty.
- R3: In queue mode, `rx_stat_o` is high exactly while the stored count is at or above the trigger level. A trigger value of 0 is treated as 1. `rx_irq_o` equals `rx_stat_o` gated by `rx_irq_en_i`, and both fall together when the count drops below the trigger.
- R4: A character offered to a full queue, with no read in the same cycle, is discarded and the count does not change. The discard sets `overrun_o`, which stays set until a `lsr_rd_i` pulse clears it. A new overrun in the same cycle as that pulse wins over the clear.
- R5: A write and a read in the same cycle on a non-empty queue leave the count unchanged and keep the order. This holds even when the queue is full, and no overrun results.
- R6: A read strobe on an empty queue leaves `rd_data_o`/`rd_err_o` at the last value read, and the count stays at zero.
- R7: With automatic flow control on, `rts_n_o` goes high one cycle after the count exceeds min(trigger + hysteresis, 64).
- R8: With automatic flow control on, `rts_n_o` returns low one cycle after the count is below max(trigger − hysteresis, 0), or after the queue is empty.
- R9: Automatic flow control is on only when both `auto_fc_en_i` and `fc_sel_i` are 1. Otherwise `rts_n_o` is the inverse of `rts_manual_i`, and the paused state is cleared, so re-enabling starts with `rts_n_o` low.
- R10: With `fifo_en_i` low, the queue holds a single character: a second write before a read is an overrun. The threshold status is high while that character is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_valid_i | input | 1 | Assembled character offered this cycle |
| wr_char_i | input | 8 | Character byte |
| wr_par_err_i | input | 1 | Parity error flag of the character |
| wr_frm_err_i | input | 1 | Framing error flag of the character |
| wr_brk_i | input | 1 | Break flag of the character |
| rd_en_i | input | 1 | Host read strobe of the data register |
| rd_data_o | output | 8 | Last character read |
| rd_err_o | output | 3 | Flags of last character read {break, framing, parity} |
| lsr_rd_i | input | 1 | Host read of line status, clears overrun |
| fifo_en_i | input | 1 | Queue mode enable |
| rx_irq_en_i | input | 1 | Receive interrupt enable |
| auto_fc_en_i | input | 1 | Automatic flow control enable, first of two |
| fc_sel_i | input | 1 | Automatic flow control enable, second of two |
| rts_manual_i | input | 1 | Manual request-to-send control bit (active high) |
| trig_lvl_i | input | 7 | Trigger level, 1 to 64 |
| hyst_i | input | 4 | Hysteresis, 0 to 15 |
| data_rdy_o | output | 1 | At least one character stored |
| overrun_o | output | 1 | Sticky overrun flag |
| rx_stat_o | output | 1 | Threshold status bit |
| rx_irq_o | output | 1 | Receive-data interrupt |
| rts_n_o | output | 1 | Active-low request-to-send |

## Verification
The embedded properties assume that `fifo_en_i` changes only while the queue is empty, and that `trig_lvl_i` and `hyst_i` stay inside their stated ranges. The stimulus respects this: it drains the queue completely before it switches modes or thresholds, and it only programs legal trigger and hysteresis values. The bench issues simultaneous writes and reads only when at least one entry is stored, so its scoreboard order is well defined.

// File: rtl/rxq_pkg.sv
// Shared types for the UART receive queue.
// Assumes an 8-bit character with three per-character error flags.
package rxq_pkg;
    localparam int CHAR_W = 8;
    localparam int FLAG_W = 3;

    typedef struct packed {
        logic              brk;
        logic              frm;
        logic              par;
        logic [CHAR_W-1:0] ch;
    } rxq_entry_t;
endpackage

// File: rtl/rxq_store.sv
// Circular entry storage with fill count.
// Capacity is DEPTH, or one entry when cap_one_i is set.
// Assumes cap_one_i changes only while the queue is empty.
// A pop on an empty queue is ignored and the output register holds.
module rxq_store
    import rxq_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int CW = $clog2(DEPTH + 1),
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push_i,
    input  logic          pop_i,
    input  logic          cap_one_i,
    input  rxq_entry_t    wr_ent_i,
    output rxq_entry_t    rd_ent_o,
    output logic [CW-1:0] count_o,
    output logic          full_o,
    output logic          drop_o
);
    rxq_entry_t    mem [DEPTH];
    logic [PW-1:0] wr_ptr, rd_ptr;
    logic          pop_ok, push_ok;
    logic [CW-1:0] cap;

    // Decide which requests take effect this cycle.
    always_comb begin
        cap     = cap_one_i ? CW'(1) : CW'(DEPTH);
        full_o  = (count_o >= cap);
        pop_ok  = pop_i && (count_o != '0);
        push_ok = push_i && (!full_o || pop_ok);
        drop_o  = push_i && !push_ok;
    end

    // Write the accepted character into the slot at the write pointer.
    always_ff @(posedge clk) begin
        if (push_ok) mem[wr_ptr] <= wr_ent_i;
    end

    // Advance the pointers, track the count, and latch the popped entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr   <= '0;
            rd_ptr   <= '0;
            count_o  <= '0;
            rd_ent_o <= '0;
        end else begin
            if (push_ok) wr_ptr <= (wr_ptr == PW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            if (pop_ok) begin
                rd_ptr   <= (rd_ptr == PW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
                rd_ent_o <= mem[rd_ptr];
            end
            case ({push_ok, pop_ok})
                2'b10:   count_o <= count_o + 1'b1;
                2'b01:   count_o <= count_o - 1'b1;
                default: count_o <= count_o;
            endcase
        end
    end

    // R4: a discarded write leaves the count unchanged.
    p_drop_keeps_count_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && full_o && !pop_i) |=> $stable(count_o));
    // R5: a write and a read on a non-empty queue cancel out in the count.
    p_push_pop_same_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && pop_i && count_o != '0) |=> $stable(count_o));
    // R6: a read of an empty queue does not underflow the count.
    p_no_underflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && !push_i && count_o == '0) |=> (count_o == '0));
    // R6: the output register holds when nothing is popped.
    p_hold_output_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!pop_i || count_o == '0) |=> $stable(rd_ent_o));
endmodule

// File: rtl/rxq_thresh.sv
// Threshold status and request-to-send hysteresis.
// Assumes the trigger level is in 1..DEPTH (0 is read as 1).
// Band edges saturate at 0 and DEPTH.
// The pause state clears whenever flow control is off.
module rxq_thresh #(
    parameter int DEPTH = 64,
    parameter int HYST_W = 4,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CW-1:0]     count_i,
    input  logic [CW-1:0]     trig_i,
    input  logic [HYST_W-1:0] hyst_i,
    input  logic              fifo_en_i,
    input  logic              fc_on_i,
    output logic              stat_o,
    output logic              hold_o
);
    logic [CW:0] eff_trig, hi_sum, hi_lvl, lo_lvl, cnt_x;

    // Compute the effective trigger and the saturated band edges.
    always_comb begin
        cnt_x    = {1'b0, count_i};
        eff_trig = (!fifo_en_i || trig_i == '0) ? (CW+1)'(1) : {1'b0, trig_i};
        hi_sum   = eff_trig + (CW+1)'(hyst_i);
        hi_lvl   = (hi_sum > (CW+1)'(DEPTH)) ? (CW+1)'(DEPTH) : hi_sum;
        lo_lvl   = (eff_trig > (CW+1)'(hyst_i)) ? eff_trig - (CW+1)'(hyst_i) : '0;
        stat_o   = (cnt_x >= eff_trig);
    end

    // Pause the remote sender above the band and release it below the band.
    always_ff @(posedge clk) begin
        if (!rst_n)                                  hold_o <= 1'b0;
        else if (!fc_on_i)                           hold_o <= 1'b0;
        else if (cnt_x > hi_lvl)                     hold_o <= 1'b1;
        else if (cnt_x < lo_lvl || count_i == '0)    hold_o <= 1'b0;
    end

    // R7: the pause state only rises after the count exceeded the upper edge.
    p_pause_above_band_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hold_o) |-> ($past(cnt_x) > $past(hi_lvl)));
    // R8: the pause state only falls below the lower edge, on empty, or when disabled.
    p_resume_below_band_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(hold_o) |-> ($past(cnt_x) < $past(lo_lvl) || $past(count_i) == '0 || !$past(fc_on_i)));
endmodule

// File: rtl/uart_rx_queue.sv
// UART receive queue top.
// Stores characters with their error flags, and drives data-ready,
// overrun, threshold status, the receive interrupt and request-to-send.
// Assumes fifo_en_i changes only while the queue is empty.
module uart_rx_queue
    import rxq_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int HYST_W = 4,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid_i,
    input  logic [7:0]        wr_char_i,
    input  logic              wr_par_err_i,
    input  logic              wr_frm_err_i,
    input  logic              wr_brk_i,
    input  logic              rd_en_i,
    output logic [7:0]        rd_data_o,
    output logic [2:0]        rd_err_o,
    input  logic              lsr_rd_i,
    input  logic              fifo_en_i,
    input  logic              rx_irq_en_i,
    input  logic              auto_fc_en_i,
    input  logic              fc_sel_i,
    input  logic              rts_manual_i,
    input  logic [CW-1:0]     trig_lvl_i,
    input  logic [HYST_W-1:0] hyst_i,
    output logic              data_rdy_o,
    output logic              overrun_o,
    output logic              rx_stat_o,
    output logic              rx_irq_o,
    output logic              rts_n_o
);
    rxq_entry_t    wr_ent, rd_ent;
    logic [CW-1:0] count;
    logic          full, drop, fc_on, hold;

    // Pack the incoming character and its flags into one entry.
    always_comb begin
        wr_ent = '{brk: wr_brk_i, frm: wr_frm_err_i, par: wr_par_err_i, ch: wr_char_i};
    end

    rxq_store #(.DEPTH(DEPTH)) store_i (
        .clk(clk), .rst_n(rst_n), .push_i(wr_valid_i), .pop_i(rd_en_i),
        .cap_one_i(!fifo_en_i), .wr_ent_i(wr_ent), .rd_ent_o(rd_ent),
        .count_o(count), .full_o(full), .drop_o(drop)
    );

    rxq_thresh #(.DEPTH(DEPTH), .HYST_W(HYST_W)) thresh_i (
        .clk(clk), .rst_n(rst_n), .count_i(count), .trig_i(trig_lvl_i),
        .hyst_i(hyst_i), .fifo_en_i(fifo_en_i), .fc_on_i(fc_on),
        .stat_o(rx_stat_o), .hold_o(hold)
    );

    // Keep the overrun flag sticky; a new drop wins over a status-read clear.
    always_ff @(posedge clk) begin
        if (!rst_n)        overrun_o <= 1'b0;
        else if (drop)     overrun_o <= 1'b1;
        else if (lsr_rd_i) overrun_o <= 1'b0;
    end

    // Derive the status outputs and pick the request-to-send source.
    always_comb begin
        fc_on      = auto_fc_en_i && fc_sel_i;
        data_rdy_o = (count != '0);
        rx_irq_o   = rx_stat_o && rx_irq_en_i;
        rts_n_o    = fc_on ? hold : !rts_manual_i;
        rd_data_o  = rd_ent.ch;
        rd_err_o   = {rd_ent.brk, rd_ent.frm, rd_ent.par};
    end

    // R2: data-ready rises only after a write was offered.
    p_ready_after_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(data_rdy_o) |-> $past(wr_valid_i));
    // R2: data-ready falls only after a read.
    p_ready_clears_on_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(data_rdy_o) |-> $past(rd_en_i));
    // R4: overrun rises only when a write met a full queue.
    p_overrun_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overrun_o) |-> ($past(wr_valid_i) && $past(full)));
    // R4: overrun stays set until a status read.
    p_overrun_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(overrun_o) |-> $past(lsr_rd_i));
endmodule

// File: tb/uart_rx_queue_tb_top.sv
// Scoreboard bench for uart_rx_queue.
// The driver pushes expected entries into a queue; the monitor pops and compares on every read.
module uart_rx_queue_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_valid_i = 0, wr_par_err_i = 0, wr_frm_err_i = 0, wr_brk_i = 0;
    logic [7:0] wr_char_i = '0;
    logic       rd_en_i = 0, lsr_rd_i = 0;
    logic       fifo_en_i = 1, rx_irq_en_i = 1, auto_fc_en_i = 1, fc_sel_i = 1, rts_manual_i = 0;
    logic [6:0] trig_lvl_i = 7'd48;
    logic [3:0] hyst_i = 4'd8;
    logic [7:0] rd_data_o;
    logic [2:0] rd_err_o;
    logic       data_rdy_o, overrun_o, rx_stat_o, rx_irq_o, rts_n_o;

    int         n_checks = 0, n_errors = 0;
    logic [10:0] sb_q[$];
    logic [10:0] last_exp = '0;
    event       rd_done;

    always #4 clk = ~clk;

    uart_rx_queue dut_i (
        .clk(clk), .rst_n(rst_n), .wr_valid_i(wr_valid_i), .wr_char_i(wr_char_i),
        .wr_par_err_i(wr_par_err_i), .wr_frm_err_i(wr_frm_err_i), .wr_brk_i(wr_brk_i),
        .rd_en_i(rd_en_i), .rd_data_o(rd_data_o), .rd_err_o(rd_err_o), .lsr_rd_i(lsr_rd_i),
        .fifo_en_i(fifo_en_i), .rx_irq_en_i(rx_irq_en_i), .auto_fc_en_i(auto_fc_en_i),
        .fc_sel_i(fc_sel_i), .rts_manual_i(rts_manual_i), .trig_lvl_i(trig_lvl_i),
        .hyst_i(hyst_i), .data_rdy_o(data_rdy_o), .overrun_o(overrun_o),
        .rx_stat_o(rx_stat_o), .rx_irq_o(rx_irq_o), .rts_n_o(rts_n_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Every task starts and ends 1 ns after a rising edge.
    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic push(input logic [2:0] e, input logic [7:0] c);
        int cap = fifo_en_i ? 64 : 1;
        {wr_brk_i, wr_frm_err_i, wr_par_err_i} = e;
        wr_char_i  = c;
        wr_valid_i = 1;
        step();
        wr_valid_i = 0;
        if (sb_q.size() < cap) sb_q.push_back({e, c});
    endtask

    task automatic pop();
        rd_en_i = 1;
        step();
        rd_en_i = 0;
        -> rd_done;
        #0;
    endtask

    task automatic push_pop(input logic [2:0] e, input logic [7:0] c);
        {wr_brk_i, wr_frm_err_i, wr_par_err_i} = e;
        wr_char_i  = c;
        wr_valid_i = 1;
        rd_en_i    = 1;
        step();
        wr_valid_i = 0;
        rd_en_i    = 0;
        -> rd_done;
        #0;
        sb_q.push_back({e, c});
    endtask

    // Monitor: pop the oldest expected entry and compare (R1, R6).
    always @(rd_done) begin
        logic [10:0] exp;
        if (sb_q.size() > 0) begin
            exp = sb_q.pop_front();
            last_exp = exp;
            chk("R1 read data", {rd_err_o, rd_data_o}, exp);
        end else begin
            chk("R6 empty read holds", {rd_err_o, rd_data_o}, last_exp);
        end
    end

    initial begin : watchdog
        #(8 * 150000);
        n_errors++;
        $display("FAIL watchdog: actual=running expected=done");
        $display("  Result: errors=%0d of %0d checks", n_errors, n_checks + 1);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        // Reset state.
        chk("R2 reset ready", data_rdy_o, 0);
        chk("R3 reset status", rx_stat_o, 0);
        chk("R4 reset overrun", overrun_o, 0);
        chk("R7 reset rts", rts_n_o, 0);

        // R2: first character sets data-ready; flags stored with it.
        push(3'b101, 8'hA5);
        chk("R2 ready after first", data_rdy_o, 1);
        for (int i = 1; i < 47; i++) push(3'(i), 8'(i));
        chk("R3 status below trigger", rx_stat_o, 0);
        chk("R3 irq below trigger", rx_irq_o, 0);
        push(3'b010, 8'h30);
        chk("R3 status at trigger", rx_stat_o, 1);
        chk("R3 irq at trigger", rx_irq_o, 1);

        // R7: pause above trigger+hysteresis (56), one cycle late.
        for (int i = 48; i < 56; i++) push(3'(i), 8'(i));
        step();
        chk("R7 rts at upper edge", rts_n_o, 0);
        push(3'b000, 8'h57);
        chk("R7 rts lags one cycle", rts_n_o, 0);
        step();
        chk("R7 rts paused", rts_n_o, 1);

        // R4: overrun on full.
        for (int i = 57; i < 64; i++) push(3'(i), 8'(i + 100));
        chk("R4 no overrun at full", overrun_o, 0);
        push(3'b111, 8'hEE);
        chk("R4 overrun set", overrun_o, 1);
        step();
        chk("R4 overrun sticky", overrun_o, 1);
        lsr_rd_i = 1; step(); lsr_rd_i = 0;
        chk("R4 overrun cleared", overrun_o, 0);

        // R5: simultaneous write and read while full.
        push_pop(3'b011, 8'h5C);
        chk("R5 no overrun on push_pop full", overrun_o, 0);

        // R3: interrupt gated by enable.
        rx_irq_en_i = 0; #1;
        chk("R3 status with irq off", rx_stat_o, 1);
        chk("R3 irq masked", rx_irq_o, 0);
        rx_irq_en_i = 1;

        // Drain to 47: status and interrupt fall together.
        while (sb_q.size() > 48) pop();
        chk("R3 status at 48", rx_stat_o, 1);
        pop();
        chk("R3 status below", rx_stat_o, 0);
        chk("R3 irq below", rx_irq_o, 0);

        // R8: resume below trigger-hysteresis (40).
        while (sb_q.size() > 40) pop();
        step();
        chk("R8 rts at lower edge", rts_n_o, 1);
        pop();
        step();
        chk("R8 rts resumed", rts_n_o, 0);

        // R5: write+read mid-queue keeps order.
        push_pop(3'b100, 8'h77);
        while (sb_q.size() > 1) pop();
        chk("R2 ready with one left", data_rdy_o, 1);
        pop();
        chk("R2 ready cleared on empty", data_rdy_o, 0);

        // R6: empty read holds data and does not underflow.
        pop();
        chk("R6 still empty", data_rdy_o, 0);
        push(3'b001, 8'h3C);
        chk("R6 one after empty read", data_rdy_o, 1);
        pop();
        chk("R6 empty again", data_rdy_o, 0);

        // R9: manual control and cleared pause state.
        for (int i = 0; i < 60; i++) push(3'(i), 8'(i + 7));
        step();
        chk("R7 paused at 60", rts_n_o, 1);
        fc_sel_i = 0; rts_manual_i = 1;
        step();
        chk("R9 manual assert", rts_n_o, 0);
        rts_manual_i = 0; #1;
        chk("R9 manual deassert", rts_n_o, 1);
        fc_sel_i = 1; #1;
        chk("R9 pause cleared", rts_n_o, 0);
        step();
        chk("R9 repause", rts_n_o, 1);
        while (sb_q.size() > 0) pop();

        // R7: saturation at top: trigger 64 never pauses.
        trig_lvl_i = 7'd64; hyst_i = 4'd8;
        for (int i = 0; i < 64; i++) push(3'b000, 8'(i));
        step();
        chk("R7 saturated upper edge", rts_n_o, 0);
        while (sb_q.size() > 0) pop();

        // R8: saturation at bottom: resume on empty.
        trig_lvl_i = 7'd4;
        for (int i = 0; i < 13; i++) push(3'b010, 8'(i + 200));
        step();
        chk("R7 paused above 12", rts_n_o, 1);
        while (sb_q.size() > 1) pop();
        step();
        chk("R8 held at one", rts_n_o, 1);
        pop();
        step();
        chk("R8 resume on empty", rts_n_o, 0);

        // R10: holding-register mode.
        fifo_en_i = 0; trig_lvl_i = 7'd48;
        push(3'b110, 8'h99);
        chk("R10 status on one", rx_stat_o, 1);
        push(3'b000, 8'h11);
        chk("R10 second is overrun", overrun_o, 1);
        pop();
        chk("R10 empty after read", data_rdy_o, 0);

        step();
        $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule